// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit timer with two compare channels. The counter advances only on timer ticks, and a 3-bit code selects how often ticks occur. The timer has two families of operation. In clear-on-compare operation, the counter climbs and drops back to zero when it equals compare value A, and each channel output can toggle, clear or set when its compare value matches. In dual-slope operation, the counter climbs from zero to a ceiling and then falls back to zero. Each output is low while the count is above its compare value on the rising slope and high once the count falls back to that value. This makes pulses that are centred on the bottom of the count, with a period of 2 × ceiling × divisor input clocks.

The counter is built around a three-state slope machine:

- RISING: the count steps up by one on each tick. At the ceiling it takes the turn transition to FALLING. If the ceiling is zero it holds in RISING.
- FALLING: the count steps down by one on each tick. At zero it takes the bottom transition back to RISING.
- WRAPPING: the state used during clear-on-compare operation. Any tick in that operation enters WRAPPING. When dual-slope operation is selected again, WRAPPING behaves like RISING.

The block raises two compare flags and an overflow flag. An interrupt request is driven from the flags through a mask.

Top module: `pwmt_timer`

## Requirements
- R1: The counter and flags change only on ticks. For `presc_sel` codes 001, 010, 011, 100 and 101, a tick occurs on the k-th clock edge after reset is released (k starting at 0) when k is a multiple of 1, 8, 64, 256 or 1024 respectively. Codes 000, 110 and 111 produce no ticks, so the count holds.
- R2: With `mode_sel` not 00, the count follows 0,1,…,TOP,TOP-1,…,1,0,1,… with one step per tick. TOP is 255 for `mode_sel`=01 and the active compare A value for `mode_sel`=10 or 11. A count above TOP while rising steps down.
- R3: With `mode_sel`=00, on each tick the count becomes 0 if it equals the active compare A value, and otherwise increments, wrapping from 255 to 0.
- R4: In dual-slope operation, the active compare values load from `cmp_a`/`cmp_b` only on the tick where the rising count is at or above TOP. In clear-on-compare operation, they load on every clock.
- R5: In dual-slope operation with channel output mode 10, the output is high when the active compare value C is nonzero and either C ≥ TOP, count < C, or count == C while the slope state is FALLING. Mode 11 gives the inverse. Modes 00 and 01 drive low.
- R6: In dual-slope operation with output mode 10, a compare value of 0 holds the output low and a value at or above TOP holds it high. With TOP=255 and compare A=191, the output is high for 382 of each 510 ticks.
- R7: In clear-on-compare operation, on a tick where the count equals a channel's active compare value, output mode 01 toggles the channel's output, 10 clears it and 11 sets it. Output mode 00 drives low.
- R8: A channel's compare flag sets on a tick where the count equals that channel's active compare value.
- R9: The overflow flag sets on a tick where the count steps down from 1 to 0 in dual-slope operation, or on a tick where the count is 255 in clear-on-compare operation.
- R10: A 1 on bit 0, 1 or 2 of `flag_clr` clears the overflow, A or B flag respectively, on that clock. A set on the same clock takes priority over the clear.
- R11: `irq` is high when any flag is high and its `irq_mask` bit is 1. Bit 0 masks overflow, bit 1 masks compare A and bit 2 masks compare B.
- R12: While reset is asserted, the count, the active compare values, all flags, both outputs and `irq` are 0, given output modes of 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | 00 clear-on-compare, 01 dual-slope with TOP=255, 1x dual-slope with TOP=compare A |
| out_mode_a | input | 2 | Output mode for channel A |
| out_mode_b | input | 2 | Output mode for channel B |
| presc_sel | input | 3 | Tick divisor code |
| cmp_a | input | 8 | Compare value A |
| cmp_b | input | 8 | Compare value B |
| irq_mask | input | 3 | Interrupt mask: {B, A, overflow} |
| flag_clr | input | 3 | Flag clear strobes: {B, A, overflow} |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| count | output | 8 | Counter value |
| flag_cmp_a | output | 1 | Compare A flag |
| flag_cmp_b | output | 1 | Compare B flag |
| flag_ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The dual-slope waveform is driven with several compare settings:

- Zero, 191 and 255 against a ceiling of 255 separate the always-low, proportional and always-high regions.
- An inverting channel at 64 confirms the polarity swap.
- A small variable ceiling of 20 shows that compare A sets the turning point.
- Moving compare A during the rising slope shows whether the shadow load waits for the turn.

Clear-on-compare runs use the toggle, set and clear output modes at short and full-range compare A values, which exercise both the compare reset and the 255 wrap. Stopped and unused divisor codes, together with the slow divisors, show whether the counter moves only on ticks.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        CNT_UP   = 2'd0,
        CNT_DOWN = 2'd1,
        CNT_WRAP = 2'd2
    } slope_e;

    typedef enum logic [1:0] {
        OM_OFF = 2'd0,
        OM_TGL = 2'd1,
        OM_NRM = 2'd2,
        OM_INV = 2'd3
    } outmode_e;

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int PRE_W = 10;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;
    logic             run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + PRE_W'(1);
    end

    always_comb begin
        run  = 1'b1;
        mask = '0;
        unique case (sel)
            3'd1:    mask = PRE_W'(0);
            3'd2:    mask = PRE_W'(7);
            3'd3:    mask = PRE_W'(63);
            3'd4:    mask = PRE_W'(255);
            3'd5:    mask = PRE_W'(1023);
            default: run  = 1'b0;
        endcase
    end

    assign tick = run && ((pre_cnt & mask) == '0);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cmp_a_in,
    input  logic [CNT_W-1:0] cmp_b_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] act_a,
    output logic [CNT_W-1:0] act_b,
    output logic [CNT_W-1:0] top,
    output logic             down,
    output logic             ctc,
    output logic             ovf_ev
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    slope_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             turn, dec;

    assign ctc  = (mode == 2'b00);
    assign top  = (mode == 2'b01) ? MAXV : act_a;
    assign down = (state_q == CNT_DOWN);

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        cnt_d   = count;
        turn    = 1'b0;
        dec     = 1'b0;
        ovf_ev  = 1'b0;
        if (ctc) begin
            state_d = CNT_WRAP;
            cnt_d   = (count == act_a) ? '0 : count + ONE;
            ovf_ev  = (count == MAXV);
        end else begin
            unique case (state_q)
                CNT_UP, CNT_WRAP: begin
                    if (count >= top) begin
                        turn = 1'b1;
                        if (count != '0) begin
                            dec     = 1'b1;
                            state_d = CNT_DOWN;
                            cnt_d   = count - ONE;
                        end else begin
                            state_d = CNT_UP;
                        end
                    end else begin
                        state_d = CNT_UP;
                        cnt_d   = count + ONE;
                    end
                end
                CNT_DOWN: begin
                    if (count != '0) begin
                        dec   = 1'b1;
                        cnt_d = count - ONE;
                    end else begin
                        state_d = CNT_UP;
                        cnt_d   = count + ONE;
                    end
                end
                default: state_d = CNT_UP;
            endcase
            ovf_ev = dec && (count == ONE);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_UP;
            count   <= '0;
        end else if (tick) begin
            state_q <= state_d;
            count   <= cnt_d;
        end
    end

    // compare shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_a <= '0;
            act_b <= '0;
        end else if (ctc || (tick && turn)) begin
            act_a <= cmp_a_in;
            act_b <= cmp_b_in;
        end
    end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctc,
    input  logic [1:0]       out_mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] act,
    input  logic [CNT_W-1:0] top,
    input  logic             down,
    output logic             wave,
    output logic             match
);
    outmode_e om;
    logic     tgl_q;
    logic     lvl;

    assign om    = outmode_e'(out_mode);
    assign match = (count == act);
    assign lvl   = (act != '0) &&
                   ((act >= top) || (count < act) || (match && down));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (tick && ctc && match) begin
            unique case (om)
                OM_TGL:  tgl_q <= ~tgl_q;
                OM_NRM:  tgl_q <= 1'b0;
                OM_INV:  tgl_q <= 1'b1;
                default: tgl_q <= tgl_q;
            endcase
        end
    end

    always_comb begin
        if (ctc) begin
            wave = (om == OM_OFF) ? 1'b0 : tgl_q;
        end else begin
            unique case (om)
                OM_NRM:  wave = lvl;
                OM_INV:  wave = ~lvl;
                default: wave = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       out_mode_a,
    input  logic [1:0]       out_mode_b,
    input  logic [2:0]       presc_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [2:0]       irq_mask,
    input  logic [2:0]       flag_clr,
    output logic             wave_a,
    output logic             wave_b,
    output logic [CNT_W-1:0] count,
    output logic             flag_cmp_a,
    output logic             flag_cmp_b,
    output logic             flag_ovf,
    output logic             irq
);
    localparam int NCH = 2;

    logic             tick, ctc, down, ovf_ev;
    logic [CNT_W-1:0] act_a, act_b, top;
    logic [CNT_W-1:0] act_v [NCH];
    logic [1:0]       om_v  [NCH];
    logic [NCH-1:0]   wave_v, match_v;
    logic [2:0]       flags_q, set_ev;

    pwmt_prescale u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (presc_sel),
        .tick (tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode_sel),
        .cmp_a_in(cmp_a),
        .cmp_b_in(cmp_b),
        .count   (count),
        .act_a   (act_a),
        .act_b   (act_b),
        .top     (top),
        .down    (down),
        .ctc     (ctc),
        .ovf_ev  (ovf_ev)
    );

    assign act_v[0] = act_a;
    assign act_v[1] = act_b;
    assign om_v[0]  = out_mode_a;
    assign om_v[1]  = out_mode_b;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .ctc     (ctc),
            .out_mode(om_v[c]),
            .count   (count),
            .act     (act_v[c]),
            .top     (top),
            .down    (down),
            .wave    (wave_v[c]),
            .match   (match_v[c])
        );
    end

    assign wave_a = wave_v[0];
    assign wave_b = wave_v[1];

    assign set_ev = {3{tick}} & {match_v[1], match_v[0], ovf_ev};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | set_ev;
    end

    assign flag_ovf   = flags_q[0];
    assign flag_cmp_a = flags_q[1];
    assign flag_cmp_b = flags_q[2];
    assign irq        = |(flags_q & irq_mask);
endmodule

// File: rtl/pwmt_timer_chk.sv
module pwmt_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic [1:0]       out_mode_b,
    input logic [2:0]       presc_sel,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] act_b,
    input logic             tick,
    input logic             wave_b,
    input logic             flag_cmp_a,
    input logic             flag_cmp_b,
    input logic             flag_ovf,
    input logic             irq
);
    // R1
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel == 3'b000) |=> $stable(count));

    // R2
    slope_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00 && $past(mode_sel) != 2'b00) |->
        (count == $past(count) || count == CNT_W'($past(count) + 1'b1) ||
         count == CNT_W'($past(count) - 1'b1)));

    // R6
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b00 && out_mode_b == 2'b10 && act_b == '0) |-> !wave_b);

    // R8
    flag_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cmp_a) |-> $past(tick));

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_ovf || flag_cmp_a || flag_cmp_b));
endmodule

bind pwmt_timer pwmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .out_mode_b(out_mode_b),
    .presc_sel (presc_sel),
    .count     (count),
    .act_b     (act_b),
    .tick      (tick),
    .wave_b    (wave_b),
    .flag_cmp_a(flag_cmp_a),
    .flag_cmp_b(flag_cmp_b),
    .flag_ovf  (flag_ovf),
    .irq       (irq)
);

// File: tb/pwmt_timer_test.sv
`timescale 1ns/1ps
module pwmt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b01, out_mode_a = 2'b10, out_mode_b = 2'b10;
    logic [2:0] presc_sel = 3'd1, irq_mask = 3'd0, flag_clr = 3'd0;
    logic [7:0] cmp_a = 8'd0, cmp_b = 8'd0;
    logic       wave_a, wave_b, flag_cmp_a, flag_cmp_b, flag_ovf, irq;
    logic [7:0] count;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwmt_timer uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .out_mode_a(out_mode_a),
        .out_mode_b(out_mode_b), .presc_sel(presc_sel), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .irq_mask(irq_mask), .flag_clr(flag_clr), .wave_a(wave_a), .wave_b(wave_b),
        .count(count), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
        .flag_ovf(flag_ovf), .irq(irq)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    int m_cnt = 0, m_dn = 0, m_aa = 0, m_ab = 0, m_k = 0;
    int m_tq [2] = '{0, 0};
    int m_fl [3] = '{0, 0, 0};

    function automatic int m_top();
        return (mode_sel == 2'b01) ? 255 : m_aa;
    endfunction

    function automatic int m_wave(int om, int tq, int act);
        bit lv;
        if (mode_sel == 2'b00) return (om != 0) ? tq : 0;
        lv = (act != 0) && (act >= m_top() || m_cnt < act || (m_cnt == act && m_dn != 0));
        if (om == 2) return int'(lv);
        if (om == 3) return int'(!lv);
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dn = 0; m_aa = 0; m_ab = 0; m_k = 0;
            m_tq = '{0, 0}; m_fl = '{0, 0, 0};
        end else begin
            int n, top, nc, nd, na, nb;
            int setv [3];
            int oms [2];
            int acts [2];
            bit tk, turn, dec;
            case (presc_sel)
                3'd1: n = 1; 3'd2: n = 8; 3'd3: n = 64;
                3'd4: n = 256; 3'd5: n = 1024; default: n = 0;
            endcase
            tk = (n != 0) && ((m_k % n) == 0);
            m_k++;
            top = m_top();
            setv = '{0, 0, 0};
            nc = m_cnt; nd = m_dn; na = m_aa; nb = m_ab;
            oms = '{int'(out_mode_a), int'(out_mode_b)};
            acts = '{m_aa, m_ab};
            if (tk) begin
                if (m_cnt == m_aa) setv[1] = 1;
                if (m_cnt == m_ab) setv[2] = 1;
                if (mode_sel == 2'b00) begin
                    if (m_cnt == 255) setv[0] = 1;
                    for (int c = 0; c < 2; c++)
                        if (m_cnt == acts[c]) begin
                            if (oms[c] == 1) m_tq[c] = 1 - m_tq[c];
                            else if (oms[c] == 2) m_tq[c] = 0;
                            else if (oms[c] == 3) m_tq[c] = 1;
                        end
                    nc = (m_cnt == m_aa) ? 0 : (m_cnt + 1) % 256;
                    nd = 0;
                end else begin
                    turn = (m_dn == 0) && (m_cnt >= top);
                    dec  = (turn || m_dn != 0) && (m_cnt != 0);
                    if (dec && m_cnt == 1) setv[0] = 1;
                    nc = dec ? m_cnt - 1 : (turn ? m_cnt : m_cnt + 1);
                    nd = int'(dec);
                    if (turn) begin na = cmp_a; nb = cmp_b; end
                end
            end
            if (mode_sel == 2'b00) begin na = cmp_a; nb = cmp_b; end
            for (int i = 0; i < 3; i++) begin
                if (flag_clr[i]) m_fl[i] = 0;
                if (setv[i] != 0) m_fl[i] = 1;
            end
            m_cnt = nc; m_dn = nd; m_aa = na; m_ab = nb;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            int ew_a, ew_b, eirq;
            ew_a = m_wave(out_mode_a, m_tq[0], m_aa);
            ew_b = m_wave(out_mode_b, m_tq[1], m_ab);
            eirq = int'(((m_fl[0] != 0) && irq_mask[0]) || ((m_fl[1] != 0) && irq_mask[1]) ||
                        ((m_fl[2] != 0) && irq_mask[2]));
            if (mode_sel == 2'b00) begin
                chk(count == m_cnt, "R3 count", count, m_cnt);
                chk(wave_a == ew_a[0] && wave_b == ew_b[0], "R7 waves",
                    {wave_a, wave_b}, ew_a * 2 + ew_b);
            end else begin
                chk(count == m_cnt, "R2 count", count, m_cnt);
                chk(wave_a == ew_a[0] && wave_b == ew_b[0], "R5 waves",
                    {wave_a, wave_b}, ew_a * 2 + ew_b);
            end
            chk(flag_cmp_a == m_fl[1][0] && flag_cmp_b == m_fl[2][0], "R8 cmp flags",
                {flag_cmp_b, flag_cmp_a}, m_fl[2] * 2 + m_fl[1]);
            chk(flag_ovf == m_fl[0][0], "R9 ovf flag", flag_ovf, m_fl[0]);
            chk(irq == eirq[0], "R11 irq", irq, eirq);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=<190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(int n, output int hi_a, output int hi_b, output int mx, output int mn);
        hi_a = 0; hi_b = 0; mx = 0; mn = 255;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            hi_a += int'(wave_a); hi_b += int'(wave_b);
            if (int'(count) > mx) mx = count;
            if (int'(count) < mn) mn = count;
        end
    endtask

    initial begin
        int ha, hb, mx, mn, hold, prev, guard;
        step(3);
        #2;
        chk(count == 0 && !flag_cmp_a && !flag_cmp_b && !flag_ovf, "R12 reset count/flags",
            count, 0);
        chk(!wave_a && !wave_b && !irq, "R12 reset outputs", {wave_a, wave_b, irq}, 0);
        @(negedge clk); rst_n = 1'b1;

        // fixed ceiling, 75% duty and the two extremes
        cmp_a = 8'd191; cmp_b = 8'd0;
        step(600);
        measure(510, ha, hb, mx, mn);
        chk(ha == 382, "R6 duty 191", ha, 382);
        chk(hb == 0, "R6 compare zero low", hb, 0);
        @(negedge clk); cmp_b = 8'd255;
        step(520);
        measure(510, ha, hb, mx, mn);
        chk(hb == 510, "R6 compare top high", hb, 510);

        // inverting channel
        @(negedge clk); out_mode_b = 2'b11; cmp_b = 8'd64; irq_mask = 3'b111;
        step(1100);

        // variable ceiling from compare A
        @(negedge clk); mode_sel = 2'b10; out_mode_b = 2'b10; cmp_a = 8'd20; cmp_b = 8'd7;
        step(600);
        measure(100, ha, hb, mx, mn);
        chk(mx == 20, "R2 ceiling max", mx, 20);
        chk(mn == 0, "R2 bottom min", mn, 0);

        // stopped divisor codes
        @(negedge clk); presc_sel = 3'd0;
        @(negedge clk); #2; hold = count;
        step(20); #2;
        chk(int'(count) == hold, "R1 code 000 holds", count, hold);
        @(negedge clk); presc_sel = 3'b110;
        @(negedge clk); #2; hold = count;
        step(20); #2;
        chk(int'(count) == hold, "R1 code 110 holds", count, hold);
        @(negedge clk); presc_sel = 3'd2;
        step(2000);

        // shadow load waits for the turn
        @(negedge clk); presc_sel = 3'd1; cmp_a = 8'd100;
        step(300);
        prev = count; guard = 0;
        while (!(count == 8'd30 && prev == 29) && guard < 1000) begin
            prev = count; @(negedge clk); guard++;
        end
        cmp_a = 8'd10;
        step(20); #2;
        chk(count == 8'd50, "R4 old ceiling kept on rising slope", count, 50);
        step(300);

        // clear-on-compare
        @(negedge clk); mode_sel = 2'b00; cmp_a = 8'd9; cmp_b = 8'd4;
        out_mode_a = 2'b01; out_mode_b = 2'b11;
        step(300);
        measure(50, ha, hb, mx, mn);
        chk(mx == 9, "R3 clears at compare A", mx, 9);
        @(negedge clk); out_mode_b = 2'b10;
        step(100);
        @(negedge clk); presc_sel = 3'd3;
        step(3000);
        @(negedge clk); presc_sel = 3'd1; cmp_a = 8'd255;
        step(600);

        // slow divisors in dual-slope
        @(negedge clk); mode_sel = 2'b10; out_mode_a = 2'b10; presc_sel = 3'd3;
        cmp_a = 8'd5; cmp_b = 8'd2;
        step(3000);
        @(negedge clk); presc_sel = 3'd5;
        step(3000);

        // flags, mask and clear
        @(negedge clk); presc_sel = 3'd0;
        step(2);
        @(negedge clk); irq_mask = 3'b010;
        #2;
        chk(flag_cmp_a == 1'b1, "R8 compare A flag held", flag_cmp_a, 1);
        chk(irq == 1'b1, "R11 masked-in flag raises irq", irq, 1);
        @(negedge clk); irq_mask = 3'b000;
        #2;
        chk(irq == 1'b0, "R11 mask off drops irq", irq, 0);
        @(negedge clk); flag_clr = 3'b111;
        @(negedge clk); flag_clr = 3'b000;
        #2;
        chk({flag_cmp_b, flag_cmp_a, flag_ovf} == 3'b000, "R10 clear strobes",
            {flag_cmp_b, flag_cmp_a, flag_ovf}, 0);

        step(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule